// File: doc/BRIEF.md
# Evaluation Stack with Separate Top Register

This block is the operand stack of a 32-bit stack processor. The topmost element is kept in a dedicated register, X, outside the stack memory. The elements beneath it live in a 64-word register array addressed by a stack pointer. The second element, Y, is always the array word at the current pointer and is available without delay, so an ALU in front of the block can read both operands in the same cycle.

On each cycle with `step` high, the block takes three inputs: a pointer adjustment of -1, 0 or +1, a flag that asks for the old top to be pushed, and a new top value. It then updates the pointer, the array and X on a single clock edge. If the push flag is set, the old X is written into the slot at the new pointer. Slot 0 never holds a live element; live elements occupy slots 1 up to the pointer. If an adjustment would move the pointer outside 0..63, the step is refused, the state is held, and an error is flagged. The pointer is also brought out so that an instruction that reads registers can copy it.

Top module: `eval_stack`

## Requirements
- R1: After reset, `sp` is 0, `top_x` is 0 and `stack_err` is 0.
- R2: `sp_adj` is a 2-bit two's-complement code: 2'b00 means 0, 2'b01 means +1 and 2'b11 means -1. On an accepted step, `sp` becomes the old pointer plus the adjustment on the next clock edge.
- R3: While `step` is low, `sp`, `top_x` and the array keep their values, whatever the other inputs are.
- R4: On an accepted step, `top_x` takes the value of `top_in` on the same edge.
- R5: On an accepted step with `push` high, the old `top_x` is written into the array slot at the new pointer. `second_y` always shows the array word at the current `sp`, without a clock delay.
- R6: On an accepted step with `push` low, the array is not written.
- R7: A step with adjustment -1 when `sp` is 0 is refused. `sp`, `top_x` and the array keep their values, and `stack_err` is high in the following cycle.
- R8: A step with adjustment +1 when `sp` is 63 is refused in the same way as in R7.
- R9: The unused code 2'b10 on `sp_adj` acts as an adjustment of 0.
- R10: `stack_err` is registered. It is high for exactly the cycle after a refused step and low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | Apply this cycle's update |
| sp_adj | input | 2 | Pointer adjustment code (R2, R9) |
| push | input | 1 | Write old top into slot at new pointer |
| top_in | input | 32 | New top-of-stack value |
| top_x | output | 32 | Top element X |
| second_y | output | 32 | Second element Y, the array word at `sp` |
| sp | output | 6 | Stack pointer |
| stack_err | output | 1 | Refused-step flag, one cycle after the step |

## Verification
Every result is due one clock edge after the step that causes it. `sp`, `top_x` and `stack_err` are registered, and `second_y` follows the new pointer and the newly written slot through combinational logic in the same cycle. The driver presents a step at a falling edge, waits for the rising edge, and then queues the state it expects. The monitor compares at the next falling edge, so every sample is taken half a period away from the edge that updated the state. `second_y` is compared only when the bench's model has written the slot it points at.

// File: rtl/eval_stack.sv
module eval_stack #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [1:0]       sp_adj,
  input  logic             push,
  input  logic [WIDTH-1:0] top_in,
  output logic [WIDTH-1:0] top_x,
  output logic [WIDTH-1:0] second_y,
  output logic [PW-1:0]    sp,
  output logic             stack_err
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [1:0]       adj_eff;
  logic [PW:0]      sp_sum;
  logic             out_of_range;
  logic             accept;

  assign adj_eff      = (sp_adj == 2'b10) ? 2'b00 : sp_adj;
  assign sp_sum       = {1'b0, sp} + {{(PW-1){adj_eff[1]}}, adj_eff};
  assign out_of_range = sp_sum[PW];
  assign accept       = step && !out_of_range;
  assign second_y     = mem[sp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp        <= '0;
      top_x     <= '0;
      stack_err <= 1'b0;
    end else begin
      stack_err <= step && out_of_range;
      if (accept) begin
        sp    <= sp_sum[PW-1:0];
        top_x <= top_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && push) mem[sp_sum[PW-1:0]] <= top_x;
  end

  AST_SP_MOVES_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sp == $past(sp) || sp == $past(sp) + 1'b1 || sp == $past(sp) - 1'b1)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(sp) && $stable(top_x))); // R3

  AST_NEW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !stack_err && sp_adj == 2'b00) |=> (top_x == $past(top_in) || stack_err)); // R4

  AST_PUSH_SHOWS_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (step && push && sp_adj == 2'b01 && sp != PW'(DEPTH-1)) |=> (second_y == $past(top_x))); // R5

  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sp_adj == 2'b11 && sp == '0) |=> (stack_err && $stable(sp) && $stable(top_x))); // R7

  AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sp_adj == 2'b01 && sp == PW'(DEPTH-1)) |=> (stack_err && $stable(sp) && $stable(top_x))); // R8

  AST_ERR_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !stack_err); // R10

endmodule

// File: tb/eval_stack_test.sv
`timescale 1ns/1ps
module eval_stack_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [1:0]  sp_adj = 2'b00;
  logic        push = 1'b0;
  logic [31:0] top_in = '0;
  logic [31:0] top_x, second_y;
  logic [5:0]  sp;
  logic        stack_err;

  always #2 clk = ~clk;

  eval_stack uut (
    .clk(clk), .rst_n(rst_n), .step(step), .sp_adj(sp_adj), .push(push),
    .top_in(top_in), .top_x(top_x), .second_y(second_y), .sp(sp), .stack_err(stack_err)
  );

  typedef struct {
    logic [5:0]  e_sp;
    logic [31:0] e_x;
    logic [31:0] e_y;
    logic        y_ok;
    logic        e_err;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int          m_sp = 0;
  logic [31:0] m_x = '0;
  logic [31:0] m_mem [64];
  bit          m_wr [64];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit st, input logic [1:0] adj, input bit ps,
                       input logic [31:0] v, input string tag);
    exp_t e;
    int a;
    int nxt;
    bit bad;
    @(negedge clk);
    step = st; sp_adj = adj; push = ps; top_in = v;
    a = (adj == 2'b01) ? 1 : (adj == 2'b11) ? -1 : 0;
    nxt = m_sp + a;
    bad = (nxt < 0) || (nxt > 63);
    if (st && !bad) begin
      if (ps) begin m_mem[nxt] = m_x; m_wr[nxt] = 1'b1; end
      m_x = v;
      m_sp = nxt;
    end
    e.e_sp = 6'(m_sp); e.e_x = m_x; e.e_y = m_mem[m_sp]; e.y_ok = m_wr[m_sp];
    e.e_err = st && bad; e.tag = tag;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " sp"}, 32'(sp), 32'(e.e_sp));
        chk({e.tag, " top_x"}, top_x, e.e_x);
        chk({e.tag, " stack_err"}, 32'(stack_err), 32'(e.e_err));
        if (e.y_ok) chk({e.tag, " second_y"}, second_y, e.e_y);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_mem[i] = '0; m_wr[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset sp", 32'(sp), 32'd0);
    chk("R1 reset top_x", top_x, 32'd0);
    chk("R1 reset stack_err", 32'(stack_err), 32'd0);
    rst_n = 1'b1;
    // R2 R4 R5 fill to the top with pushes
    for (int i = 1; i <= 63; i++) drive(1, 2'b01, 1, 32'hA000_0000 + 32'(i), "R5 push");
    // R8 overflow refused, then R10 error clears
    drive(1, 2'b01, 1, 32'hDEAD_0001, "R8 overflow");
    drive(0, 2'b00, 0, 32'h0, "R10 err clears");
    // R3 idle with noisy inputs
    drive(0, 2'b11, 1, 32'h1234_5678, "R3 idle");
    drive(0, 2'b01, 0, 32'h8765_4321, "R3 idle");
    // R9 reserved code acts as hold, R4 new top
    drive(1, 2'b10, 0, 32'h5555_AAAA, "R9 code10");
    // R6 pop without push leaves array intact
    for (int i = 0; i < 5; i++) drive(1, 2'b11, 0, 32'hB000_0000 + 32'(i), "R6 pop");
    // R5 push with zero adjustment overwrites Y
    drive(1, 2'b00, 1, 32'hC0DE_0001, "R5 push adj0");
    // R5 push with -1 adjustment
    drive(1, 2'b11, 1, 32'hC0DE_0002, "R5 push dec");
    // R4 replace top only
    drive(1, 2'b00, 0, 32'hF00D_F00D, "R4 replace");
    // drain to zero
    while (m_sp > 0) drive(1, 2'b11, 0, 32'h7000_0000 + 32'(m_sp), "R2 drain");
    // R7 underflow refused
    drive(1, 2'b11, 1, 32'hBAD0_0001, "R7 underflow");
    drive(1, 2'b11, 0, 32'hBAD0_0002, "R7 underflow again");
    drive(1, 2'b01, 1, 32'h0000_0042, "R10 ok after err");
    drive(0, 2'b00, 0, 32'h0, "R10 settle");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule